// File: doc/BRIEF.md
# Double-Buffered DAC Register Control

This block keeps the two code registers of a single-channel voltage DAC, a staging register and an output register, and it tracks whether the output amplifier is powered. The serial receiver decodes each frame and hands over single-cycle strobes for write, update and power-down together with a data word. Three pins arrive separately: an active-low asynchronous update pin, an active-low clear pin and the chip-select/load level. The block drives the output register code, a powered-up flag and a flag that puts the analog output into high impedance.

The main job is to settle conflicts between software updates and the asynchronous update pin. When the pin falls while chip-select is high, the staging register is copied into the output register straight away. When the pin falls during a transfer, the DAC powers up at once, but the copy is held until chip-select rises. The copy then happens only if the pin is still low. In that case the received command runs first, so freshly written data reaches the output register in the same cycle. A three-state machine does this tracking. ST_IDLE means chip-select is high. ST_XFER means a transfer is open with no pin event. ST_ARMED means a transfer is open and the pin has fallen. ST_IDLE goes to ST_XFER when chip-select falls, or to ST_ARMED if the pin falls in that same cycle. ST_XFER goes to ST_ARMED when the pin falls. Both ST_XFER and ST_ARMED return to ST_IDLE when chip-select rises.

The update pin passes through a two-flop synchronizer and an edge detector. The clear pin resets the registers asynchronously and is released synchronously after two clock edges.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: After reset, dac_code is 0, powered_up is 1 and out_hiz is 0.
- R2: A cycle with cmd_write high and cmd_update low loads cmd_data into the staging register only. dac_code does not change, and a later update shows the loaded value.
- R3: A cycle with cmd_update high and cmd_write low copies the staging register to dac_code at the next clock edge.
- R4: When cmd_write and cmd_update are both high in one cycle, cmd_data appears on dac_code at the next clock edge.
- R5: Any update, whether by command or by the update pin, sets powered_up to 1.
- R6: A cmd_pwrdn strobe, with ldac_n high, clears powered_up at the next edge. Neither register changes, which a later update shows.
- R7: With cs_ld high, a falling edge on ldac_n copies the staging register to dac_code. The copy appears at the third clock edge after the pin changes, and not before.
- R8: If ldac_n falls while cs_ld is low, powered_up becomes 1 and dac_code holds until cs_ld rises. At that point the copy happens only if ldac_n is still low. If the pin has returned high, the pending copy is dropped.
- R9: While the synchronized ldac_n is low, powered_up stays 1 and any cmd_pwrdn strobe is ignored.
- R10: While clr_n is low, both registers read zero at once and command strobes are ignored. Strobes are also ignored at the first clock edge after clr_n returns high.
- R11: When cs_ld rises with a pending pin update, the strobed command takes effect first. A write-only command therefore puts its new data on dac_code in that same cycle.
- R12: out_hiz is always the inverse of powered_up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_ld | input | 1 | Chip-select/load level, synchronous to clk; low while a transfer is open |
| cmd_write | input | 1 | Strobe: load cmd_data into the staging register |
| cmd_update | input | 1 | Strobe: copy the staging register to the output register |
| cmd_pwrdn | input | 1 | Strobe: power the DAC down |
| cmd_data | input | CODE_W | Data word that goes with cmd_write |
| ldac_n | input | 1 | Asynchronous update pin, active low |
| clr_n | input | 1 | Asynchronous clear pin, active low |
| dac_code | output | CODE_W | Output register code |
| powered_up | output | 1 | DAC power state |
| out_hiz | output | 1 | Selects the high-impedance analog output |

## Verification
Command strobes sampled at one clock edge show their effect on dac_code and powered_up right after that edge. The bench therefore checks one falling edge after each strobe. A change on ldac_n passes through two synchronizer stages, so its copy lands at the third edge. The bench checks this window directly: it confirms the old code after two edges and the new code after three, and it waits at least four edges before any mid-transfer or post-transfer check that relies on the pin. Clear acts between edges and is checked one nanosecond after clr_n falls. Its release is checked by placing a strobe on the first edge afterwards and confirming that the strobe had no effect.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    // Arbitration state for the asynchronous update pin
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // chip-select high
        ST_XFER  = 2'd1,   // transfer open, no pin event seen
        ST_ARMED = 2'd2    // transfer open, pin fell: update pending
    } arb_state_t;
endpackage

// File: rtl/dbuf_sync.sv
module dbuf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= {STAGES{RST_VAL}};
        else         chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbuf_arbiter.sv
module dbuf_arbiter
    import dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_ld,
    input  logic ldac_lo,
    input  logic upd_cmd,
    input  logic pd_cmd,
    output logic ldac_upd,
    output logic pwr_on
);
    arb_state_t state_q, state_d;
    logic       ldac_lo_q;
    logic       ldac_fall;

    assign ldac_fall = ldac_lo && !ldac_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ldac_lo_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ldac_lo_q <= ldac_lo;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_ld) state_d = ldac_fall ? ST_ARMED : ST_XFER;
            ST_XFER:  if (cs_ld) state_d = ST_IDLE;
                      else if (ldac_fall) state_d = ST_ARMED;
            ST_ARMED: if (cs_ld) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ldac_upd = 1'b0;
        unique case (state_q)
            ST_IDLE:  ldac_upd = cs_ld && ldac_fall;
            ST_XFER:  ldac_upd = cs_ld && ldac_fall;
            ST_ARMED: ldac_upd = cs_ld && ldac_lo;
            default:  ldac_upd = 1'b0;
        endcase
    end

    // Low pin level or any update powers up; pin low masks power-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             pwr_on <= 1'b1;
        else if (upd_cmd || ldac_upd || ldac_lo) pwr_on <= 1'b1;
        else if (pd_cmd)                        pwr_on <= 1'b0;
    end
endmodule

// File: rtl/dbuf_regs.sv
module dbuf_regs #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              ld_in,
    input  logic [CODE_W-1:0] in_data,
    input  logic              ld_dac,
    output logic [CODE_W-1:0] in_code,
    output logic [CODE_W-1:0] dac_code
);
    logic [CODE_W-1:0] in_next;

    // Command data is merged ahead of the copy so a write reaches the DAC in one cycle
    assign in_next = ld_in ? in_data : in_code;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            in_code  <= '0;
            dac_code <= '0;
        end else begin
            in_code <= in_next;
            if (ld_dac) dac_code <= in_next;
        end
    end
endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl #(
    parameter int CODE_W    = 16,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_ld,
    input  logic              cmd_write,
    input  logic              cmd_update,
    input  logic              cmd_pwrdn,
    input  logic [CODE_W-1:0] cmd_data,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic [CODE_W-1:0] dac_code,
    output logic              powered_up,
    output logic              out_hiz
);
    logic              ldac_sync;
    logic              ldac_lo;
    logic              clr_arst_n;
    logic              reg_rst_n;
    logic              ldac_upd;
    logic              upd_ok;
    logic              pd_ok;
    logic              wr_ok;
    logic [CODE_W-1:0] in_code;

    dbuf_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_ldac_sync (
        .clk(clk), .arst_n(rst_n), .d(ldac_n), .q(ldac_sync)
    );

    assign clr_arst_n = rst_n && clr_n;

    dbuf_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_clr_sync (
        .clk(clk), .arst_n(clr_arst_n), .d(1'b1), .q(reg_rst_n)
    );

    assign ldac_lo = !ldac_sync;
    assign wr_ok   = cmd_write  && reg_rst_n;
    assign upd_ok  = cmd_update && reg_rst_n;
    assign pd_ok   = cmd_pwrdn  && reg_rst_n;

    dbuf_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .cs_ld(cs_ld), .ldac_lo(ldac_lo),
        .upd_cmd(upd_ok), .pd_cmd(pd_ok), .ldac_upd(ldac_upd), .pwr_on(powered_up)
    );

    dbuf_regs #(.CODE_W(CODE_W)) u_regs (
        .clk(clk), .arst_n(reg_rst_n), .ld_in(wr_ok), .in_data(cmd_data),
        .ld_dac(upd_ok || ldac_upd), .in_code(in_code), .dac_code(dac_code)
    );

    assign out_hiz = !powered_up;
endmodule

// File: rtl/dac_dbuf_ctrl_chk.sv
module dac_dbuf_ctrl_chk #(
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rst_n,
    input logic              clr_n,
    input logic              cs_ld,
    input logic              cmd_write,
    input logic              cmd_update,
    input logic              ldac_lo,
    input logic              ldac_upd,
    input logic [CODE_W-1:0] in_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              powered_up,
    input logic              out_hiz
);
    a_r12_hiz_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz == !powered_up);

    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == '0 && in_code == '0));

    a_r3_update_copies: assert property (@(posedge clk) disable iff (!reg_rst_n)
        (cmd_update && !cmd_write) |=> dac_code == $past(in_code));

    a_r9_ldac_powers: assert property (@(posedge clk) disable iff (!rst_n)
        ldac_lo |=> powered_up);

    a_r8_no_copy_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_ld |-> !ldac_upd);

    a_r2_hold_without_update: assert property (@(posedge clk) disable iff (!reg_rst_n)
        (!cmd_update && !ldac_upd) |=> $stable(dac_code));
endmodule

bind dac_dbuf_ctrl dac_dbuf_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rst_n(reg_rst_n), .clr_n(clr_n),
    .cs_ld(cs_ld), .cmd_write(cmd_write), .cmd_update(cmd_update),
    .ldac_lo(ldac_lo), .ldac_upd(ldac_upd), .in_code(in_code),
    .dac_code(dac_code), .powered_up(powered_up), .out_hiz(out_hiz)
);

// File: tb/dac_dbuf_ctrl_bench.sv
module dac_dbuf_ctrl_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n, cs_ld, cmd_write, cmd_update, cmd_pwrdn, ldac_n, clr_n;
    logic [W-1:0] cmd_data;
    logic [W-1:0] dac_code;
    logic         powered_up, out_hiz;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [W-1:0] m_in, m_dac;
    logic         m_pwr;

    always #2 clk = !clk;

    dac_dbuf_ctrl #(.CODE_W(W)) u_dac_dbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_ld(cs_ld), .cmd_write(cmd_write),
        .cmd_update(cmd_update), .cmd_pwrdn(cmd_pwrdn), .cmd_data(cmd_data),
        .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(dac_code),
        .powered_up(powered_up), .out_hiz(out_hiz)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " code"}, 32'(dac_code), 32'(m_dac));
        chk({tag, " pwr"}, 32'(powered_up), 32'(m_pwr));
        chk("R12 hiz", 32'(out_hiz), 32'(!m_pwr));
    endtask

    task automatic cmd(input logic w, input logic u, input logic p, input logic [W-1:0] d);
        cmd_write = w; cmd_update = u; cmd_pwrdn = p; cmd_data = d;
        step(1);
        cmd_write = 1'b0; cmd_update = 1'b0; cmd_pwrdn = 1'b0;
    endtask

    // mode 0: no pin event, 1: pin pulse inside transfer, 2: pin low across the rise
    task automatic xfer(input int mode, input logic w, input logic u, input logic p,
                        input logic [W-1:0] d, input string tag);
        cs_ld = 1'b0;
        step(2);
        if (mode > 0) begin
            ldac_n = 1'b0;
            step(4);
            m_pwr = 1'b1;
            chk("R8 power during transfer", 32'(powered_up), 32'd1);
            chk("R8 code held during transfer", 32'(dac_code), 32'(m_dac));
            if (mode == 1) ldac_n = 1'b1;
        end
        step(4);
        cs_ld = 1'b1;
        cmd(w, u, p, d);
        if (w) m_in = d;
        if (u || mode == 2) begin
            m_dac = m_in;
            m_pwr = 1'b1;
        end else if (p) m_pwr = 1'b0;
        chk_all(tag);
        ldac_n = 1'b1;
        step(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_ld = 1'b1; ldac_n = 1'b1; clr_n = 1'b1;
        cmd_write = 1'b0; cmd_update = 1'b0; cmd_pwrdn = 1'b0; cmd_data = '0;
        step(3);
        rst_n = 1'b1;
        step(3);
        m_in = '0; m_dac = '0; m_pwr = 1'b1;
        chk_all("R1 reset");

        // R2 then R7: write only, then pin edge with chip-select high
        cmd(1'b1, 1'b0, 1'b0, 16'hABCD); m_in = 16'hABCD;
        chk("R2 write leaves code", 32'(dac_code), 32'd0);
        ldac_n = 1'b0;
        step(2);
        chk("R7 not before third edge", 32'(dac_code), 32'd0);
        step(1);
        m_dac = m_in;
        chk("R7 pin copy", 32'(dac_code), 32'(m_dac));
        ldac_n = 1'b1;
        step(4);

        // R6 then R3/R5
        cmd(1'b1, 1'b0, 1'b0, 16'h1234); m_in = 16'h1234;
        cmd(1'b0, 1'b0, 1'b1, 16'hFFFF); m_pwr = 1'b0;
        chk_all("R6 power-down");
        cmd(1'b0, 1'b1, 1'b0, 16'h0000); m_dac = m_in; m_pwr = 1'b1;
        chk_all("R3 R5 update after power-down");

        // R5 by pin, R9 power-down ignored while pin low
        cmd(1'b0, 1'b0, 1'b1, 16'h0000); m_pwr = 1'b0;
        chk_all("R6 power-down again");
        ldac_n = 1'b0;
        step(4); m_pwr = 1'b1;
        chk_all("R5 pin update powers up");
        cmd(1'b0, 1'b0, 1'b1, 16'h0000);
        chk_all("R9 power-down ignored");
        ldac_n = 1'b1;
        step(4);

        // Sweep: pin mode x command kind
        for (int mode = 0; mode < 3; mode++) begin
            for (int c = 0; c < 5; c++) begin
                logic [W-1:0] d;
                string tag;
                d = W'(16'h1357 * (c + 1) + mode * 16'h0404);
                if (mode == 2)      tag = "R11";
                else if (c == 2)    tag = "R4";
                else if (c == 1)    tag = "R3";
                else if (c == 0)    tag = "R2";
                else if (c == 3)    tag = "R6";
                else                tag = "R8";
                if (mode == 1 && c != 1 && c != 2) tag = "R8 dropped";
                xfer(mode, c == 0 || c == 2, c == 1 || c == 2, c == 3, d, tag);
                if (mode == 2 && c == 3)
                    chk("R9 power-down masked at rise", 32'(powered_up), 32'd1);
            end
        end

        // R10 clear
        cmd(1'b1, 1'b1, 1'b0, 16'h4444); m_in = 16'h4444; m_dac = m_in; m_pwr = 1'b1;
        chk_all("R4 before clear");
        clr_n = 1'b0;
        #1;
        chk("R10 async clear", 32'(dac_code), 32'd0);
        step(1);
        cmd(1'b1, 1'b0, 1'b0, 16'h7777);
        clr_n = 1'b1;
        cmd(1'b1, 1'b0, 1'b0, 16'h5555);
        step(2);
        cmd(1'b0, 1'b1, 1'b0, 16'h0000);
        m_in = '0; m_dac = '0;
        chk_all("R10 writes ignored");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule